// File: doc/BRIEF.md
# Shared Bus Requester with Hold Timeout

This block lets one board's processor borrow a shared system bus that several boards contend for. When the processor addresses the shared bus and its address strobe is active, the block drives an active-low request to an external arbiter. It then waits for the arbiter's active-low grant, which arrives asynchronously and is passed through a two-stage synchroniser. Once the grant is seen, the request is dropped. The block then drives an active-low busy line to the arbiter and enables the board's data, address and control bus couplers. It keeps all of these asserted until the processor ends the access by releasing its strobe.

A hold timer guards the access. It counts timer ticks from the board's clock generator while the shared-bus chip enable is active and a request or an ownership is in progress. It restarts from zero whenever the chip enable goes inactive. If the count reaches the configured limit, the block gives up the bus and drives an active-low bus error to halt the processor. That error stays asserted, and no new request is issued, until the processor releases its address strobe.

All pins are plain control and status lines. No data moves through the block, so there is no valid/ready interface and no back-pressure.

Top module: `shbus_requester`

## Requirements
- R1: After reset, the request, busy and bus error outputs (all active low) read 1 and every coupler enable reads 0.
- R2: While idle, with the access request high and the address strobe low on a clock edge, the request output goes low after that edge.
- R3: The grant input passes through two synchroniser flops. After the grant goes low while a request is pending, the block takes ownership on the third rising edge and not before.
- R4: While the block owns the bus, the request output is 1, busy is 0 and all three coupler enables (bit 0 data, bit 1 address, bit 2 control) are 1. This holds for as long as the address strobe stays low.
- R5: When the address strobe goes high during ownership, busy returns to 1 and the coupler enables return to 0 after the next edge.
- R6: With the chip enable low during a request or ownership, the bus error goes low on the TIMEOUT_TICKS-th counted tick. At the same edge, request and busy go to 1 and the coupler enables go to 0.
- R7: When the chip enable goes high, the hold timer restarts from zero. A fresh run of TIMEOUT_TICKS counted ticks is then needed before an error.
- R8: The hold timer advances only on edges where the tick input is high. Edges with the tick low leave the count unchanged.
- R9: The bus error stays at 0 while the address strobe stays low. No request is raised during that time, even with the access request held high. The error clears on the edge after the strobe goes high.
- R10: A grant that arrives while no request is pending has no effect: busy and the coupler enables stay inactive.
- R11: If the address strobe goes high while a request is pending, the request is withdrawn after the next edge.
- R12: Request and busy are never low together. The bus error is never low together with either of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor is addressing the shared bus |
| as_n | input | 1 | Processor address strobe, active low |
| bus_ce_n | input | 1 | Shared-bus chip enable, active low; gates the hold timer |
| tmo_tick | input | 1 | Timer tick from the clock generator, one clock wide |
| bg_n | input | 1 | Grant from the arbiter, active low, asynchronous |
| br_n | output | 1 | Request to the arbiter, active low |
| busy_n | output | 1 | Shared bus in use by this board, active low |
| cpl_en | output | NUM_CPL | Coupler enables: bit 0 data, bit 1 address, bit 2 control |
| berr_n | output | 1 | Bus error to the processor, active low |

## Verification
On every cycle, the assertions check that the handshake outputs exclude one another and that the coupler enables track busy. They also check that a strobe release ends ownership or a pending request, that the bus error holds while the strobe stays low, and that busy only falls after a request. The timing of the synchroniser delay, the exact tick on which the timer expires, the timer restart when the chip enable drops, tick gating, and the refusal of new requests during an error can only be shown by the bench's directed scenarios. Those scenarios sample each output on the cycle where it is expected to change.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_OWN   = 2'd2,
    ST_ERR   = 2'd3
  } shbus_state_t;

endpackage

// File: rtl/shbus_sync.sv
module shbus_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/shbus_timer.sv
module shbus_timer #(
  parameter int TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  // Count ticks while running; any pause in run restarts from zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (expire)        cnt <= '0;
    else if (tick)          cnt <= cnt + CW'(1);
  end

  assign expire = run && tick && (cnt == LAST);

endmodule

// File: rtl/shbus_fsm.sv
module shbus_fsm
  import shbus_pkg::*;
#(
  parameter int NUM_CPL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               as_act,
  input  logic               ce_act,
  input  logic               grant,
  input  logic               expire,
  output logic               run,
  output logic               br_n,
  output logic               busy_n,
  output logic               berr_n,
  output logic [NUM_CPL-1:0] cpl_en
);

  shbus_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (cpu_req && as_act) state_nx = ST_REQ;
      ST_REQ: begin
        if (!as_act)     state_nx = ST_IDLE;
        else if (expire) state_nx = ST_ERR;
        else if (grant)  state_nx = ST_OWN;
      end
      ST_OWN: begin
        if (!as_act)     state_nx = ST_IDLE;
        else if (expire) state_nx = ST_ERR;
      end
      ST_ERR: if (!as_act) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign run    = ce_act && ((state == ST_REQ) || (state == ST_OWN));
  assign br_n   = (state != ST_REQ);
  assign busy_n = (state != ST_OWN);
  assign berr_n = (state != ST_ERR);
  assign cpl_en = {NUM_CPL{state == ST_OWN}};

endmodule

// File: rtl/shbus_requester.sv
module shbus_requester #(
  parameter int TIMEOUT_TICKS = 1024,
  parameter int SYNC_STAGES   = 2,
  parameter int NUM_CPL       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               as_n,
  input  logic               bus_ce_n,
  input  logic               tmo_tick,
  input  logic               bg_n,
  output logic               br_n,
  output logic               busy_n,
  output logic [NUM_CPL-1:0] cpl_en,
  output logic               berr_n
);

  logic bg_n_s;
  logic run;
  logic expire;

  shbus_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_bg_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bg_n),
    .q     (bg_n_s)
  );

  shbus_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick   (tmo_tick),
    .expire (expire)
  );

  shbus_fsm #(.NUM_CPL(NUM_CPL)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (cpu_req),
    .as_act  (!as_n),
    .ce_act  (!bus_ce_n),
    .grant   (!bg_n_s),
    .expire  (expire),
    .run     (run),
    .br_n    (br_n),
    .busy_n  (busy_n),
    .berr_n  (berr_n),
    .cpl_en  (cpl_en)
  );

endmodule

// File: rtl/shbus_requester_chk.sv
module shbus_requester_chk #(
  parameter int NUM_CPL = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               as_n,
  input logic               br_n,
  input logic               busy_n,
  input logic               berr_n,
  input logic [NUM_CPL-1:0] cpl_en
);

  assert_excl_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!br_n && !busy_n));

  assert_err_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n |-> (br_n && busy_n));

  assert_cpl_tracks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_en == {NUM_CPL{1'b1}}) == !busy_n && (cpl_en == '0) == busy_n);

  assert_release_ends_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && as_n) |=> busy_n);

  assert_err_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && !as_n) |=> !berr_n);

  assert_abort_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_n && as_n) |=> br_n);

  assert_idle_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_n && busy_n && berr_n && cpu_req && !as_n) |=> !br_n);

  assert_own_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!br_n));

endmodule

bind shbus_requester shbus_requester_chk #(.NUM_CPL(NUM_CPL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cpu_req (cpu_req),
  .as_n    (as_n),
  .br_n    (br_n),
  .busy_n  (busy_n),
  .berr_n  (berr_n),
  .cpl_en  (cpl_en)
);

// File: tb/shbus_requester_tb.sv
`timescale 1ns/1ps
module shbus_requester_tb;

  localparam int T = 16;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0;
  logic as_n = 1'b1;
  logic bus_ce_n = 1'b1;
  logic tmo_tick = 1'b1;
  logic bg_n = 1'b1;
  logic br_n, busy_n, berr_n;
  logic [N-1:0] cpl_en;

  int nvec = 0;
  int nerr = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shbus_requester #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2), .NUM_CPL(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .as_n(as_n),
    .bus_ce_n(bus_ce_n), .tmo_tick(tmo_tick), .bg_n(bg_n),
    .br_n(br_n), .busy_n(busy_n), .cpl_en(cpl_en), .berr_n(berr_n)
  );

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nerr++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      summary();
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cpu_req = 0; as_n = 1; bus_ce_n = 1; tmo_tick = 1; bg_n = 1;
    step(4);
  endtask

  task automatic go_owned();
    cpu_req = 1; as_n = 0;
    step();
    check("R2 request low", br_n, 0);
    bg_n = 0;
    step(2);
    check("R3 no ownership before third edge", busy_n, 1);
    step();
    check("R3 busy on third edge", busy_n, 0);
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(2);
    check("R1 br_n", br_n, 1);
    check("R1 busy_n", busy_n, 1);
    check("R1 berr_n", berr_n, 1);
    check("R1 cpl_en", cpl_en, 0);
    rst_n = 1;
    step(2);
  endtask

  task automatic t_normal();
    go_owned();
    check("R4 request dropped", br_n, 1);
    check("R4 couplers on", cpl_en, 3'b111);
    bg_n = 1;
    step(5);
    check("R4 busy held", busy_n, 0);
    check("R4 couplers held", cpl_en, 3'b111);
    as_n = 1;
    step();
    check("R5 busy released", busy_n, 1);
    check("R5 couplers off", cpl_en, 0);
    quiet();
  endtask

  task automatic t_abort();
    cpu_req = 1; as_n = 0;
    step();
    check("R2 request", br_n, 0);
    as_n = 1;
    step();
    check("R11 request withdrawn", br_n, 1);
    check("R11 no busy", busy_n, 1);
    quiet();
  endtask

  task automatic t_ignore_grant();
    bg_n = 0;
    step(6);
    check("R10 busy idle", busy_n, 1);
    check("R10 couplers idle", cpl_en, 0);
    check("R10 no request", br_n, 1);
    quiet();
  endtask

  task automatic t_timeout();
    cpu_req = 1; as_n = 0;
    step();
    check("R2 request", br_n, 0);
    bus_ce_n = 0;
    step(T - 1);
    check("R6 no error yet", berr_n, 1);
    step();
    check("R6 error raised", berr_n, 0);
    check("R6 request dropped", br_n, 1);
    check("R6 busy inactive", busy_n, 1);
    check("R6 couplers off", cpl_en, 0);
    bg_n = 0;
    step(5);
    check("R9 error held", berr_n, 0);
    check("R10 grant ignored in error", busy_n, 1);
    check("R9 no new request", br_n, 1);
    bg_n = 1; bus_ce_n = 1;
    step(3);
    check("R9 error held after ce off", berr_n, 0);
    as_n = 1;
    step();
    check("R9 error cleared", berr_n, 1);
    check("R9 still no request", br_n, 1);
    quiet();
  endtask

  task automatic t_ce_clear();
    go_owned();
    bg_n = 1;
    bus_ce_n = 0;
    step(T - 2);
    bus_ce_n = 1;
    step();
    bus_ce_n = 0;
    step(T - 1);
    check("R7 restarted, no error", berr_n, 1);
    check("R7 still owned", busy_n, 0);
    step();
    check("R7 error after full run", berr_n, 0);
    quiet();
  endtask

  task automatic t_tick_gate();
    go_owned();
    bg_n = 1;
    tmo_tick = 0;
    bus_ce_n = 0;
    step(3 * T);
    check("R8 no count without tick", berr_n, 1);
    tmo_tick = 1;
    step(T - 1);
    check("R8 one tick short", berr_n, 1);
    step();
    check("R8 error on last tick", berr_n, 0);
    quiet();
  endtask

  initial begin
    step(2);
    t_reset();
    t_normal();
    t_abort();
    t_ignore_grant();
    t_timeout();
    t_ce_clear();
    t_tick_gate();
    summary();
  end

endmodule